// File: doc/BRIEF.md
# Link Sleep Request Handshake Controller

This block runs the handshake that takes an automotive Ethernet PHY link from normal operation into a low-power sleep. A local sleep command moves the controller from `NORMAL` into an intermediate `SLEEP_REQ` state. While it is there, it asks the transmit path to send low-power-sleep (LPS) code-groups, so that the link partner learns that sleep is wanted. It also starts a timeout counted in ticks of an internal 1 µs enable. When the receive path decodes LPS from the partner, the controller moves to `SLEEP_SILENT`. If the timeout runs out first, it moves to `SLEEP_FAIL`. Every decoded LPS also sets a sticky interrupt flag, which management clears by writing one.

The states and transitions are:
- `NORMAL -> SLEEP_REQ` on `sleep_cmd`.
- `SLEEP_REQ -> SLEEP_SILENT` on `lps_rx`. This wins over the timeout when both happen on the same edge.
- `SLEEP_REQ -> SLEEP_FAIL` on timeout expiry.
- `SLEEP_FAIL -> NORMAL` on `fail_ack`.
- `SLEEP_SILENT -> NORMAL` on `wake`.

Any other input in a state holds that state. Line coding, symbol generation and analog power sequencing sit outside the block. The block sees them only as the `lps_tx_req` level and the `lps_rx` strobe.

Top module: `lps_sleep_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters NORMAL, drops `lps_tx_req`, clears `irq_lps`, and loads the timeout register with DEF_TIMEOUT.
- R2: `sleep_cmd` in NORMAL moves the block to SLEEP_REQ at that edge. `sleep_cmd` in any other state has no effect.
- R3: `lps_tx_req` is high exactly while the block is in SLEEP_REQ. It drops on the edge that leaves SLEEP_REQ, whether the exit goes to SLEEP_SILENT or to SLEEP_FAIL.
- R4: `lps_rx` high in SLEEP_REQ moves the block to SLEEP_SILENT at that edge.
- R5: With timeout value N ≥ 1 and CLK_PER_US = K, the block enters SLEEP_FAIL exactly N·K edges after the edge that entered SLEEP_REQ, unless LPS arrives earlier. The count restarts from zero on every entry.
- R6: When `lps_rx` arrives on the same edge as timeout expiry, the block enters SLEEP_SILENT, not SLEEP_FAIL.
- R7: After reset the timeout is 16000 ticks (16 ms). A `cfg_wr` pulse loads `cfg_timeout` into the timeout register.
- R8: `lps_rx` sets `irq_lps` at that edge in any state, and the flag stays set. `irq_clr` clears it. When `lps_rx` and `irq_clr` come together, the flag is set.
- R9: In SLEEP_FAIL, `fail_ack` returns the block to NORMAL at that edge. `wake` and `sleep_cmd` have no effect in SLEEP_FAIL.
- R10: In SLEEP_SILENT, `wake` returns the block to NORMAL at that edge. `fail_ack` and `sleep_cmd` have no effect in SLEEP_SILENT.
- R11: Exactly one of `in_normal`, `lps_tx_req`, `in_silent` and `in_fail` is high at any time outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_cmd | input | 1 | Local request to start sleep entry |
| lps_rx | input | 1 | Strobe from receive path: LPS decoded from partner |
| wake | input | 1 | Wake event, leaves SLEEP_SILENT |
| fail_ack | input | 1 | Host acknowledge, leaves SLEEP_FAIL |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| cfg_wr | input | 1 | Load strobe for the timeout register |
| cfg_timeout | input | TMR_W | New timeout in 1 µs ticks |
| lps_tx_req | output | 1 | Ask transmit path to send LPS code-groups (SLEEP_REQ) |
| in_normal | output | 1 | Block is in NORMAL |
| in_silent | output | 1 | Block is in SLEEP_SILENT |
| in_fail | output | 1 | Block is in SLEEP_FAIL |
| irq_lps | output | 1 | Sticky LPS-received interrupt flag |

## Verification
The properties assume that every input is a synchronous level, sampled only at the rising edge. They also assume that a programmed timeout is never zero, because the cycle-exact fail timing holds only for N ≥ 1. The stimulus changes inputs only on the falling clock edge, so the timing assumption holds. It writes only nonzero timeouts and drives strobes in every state, including combinations that must be ignored. That way, the hold and priority properties get exercised outside the paths that trigger them.

// File: rtl/lps_sleep_pkg.sv
package lps_sleep_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL       = 2'd0,
        ST_SLEEP_REQ    = 2'd1,
        ST_SLEEP_SILENT = 2'd2,
        ST_SLEEP_FAIL   = 2'd3
    } slp_state_t;

endpackage

// File: rtl/lps_us_tick.sv
module lps_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (run) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign tick = run && (div_q == DIV_LAST);

endmodule

// File: rtl/lps_req_timer.sv
module lps_req_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [TMR_W-1:0] limit,
    output logic             expire
);
    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= next_cnt[TMR_W-1:0];
        end
    end

    assign expire = run && tick && (next_cnt >= {1'b0, limit});

endmodule

// File: rtl/lps_irq_flag.sv
module lps_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_evt) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/lps_sleep_ctrl.sv
module lps_sleep_ctrl
    import lps_sleep_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int TMR_W       = 16,
    parameter int DEF_TIMEOUT = 16000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_cmd,
    input  logic             lps_rx,
    input  logic             wake,
    input  logic             fail_ack,
    input  logic             irq_clr,
    input  logic             cfg_wr,
    input  logic [TMR_W-1:0] cfg_timeout,
    output logic             lps_tx_req,
    output logic             in_normal,
    output logic             in_silent,
    output logic             in_fail,
    output logic             irq_lps
);
    localparam logic [TMR_W-1:0] TMO_RST = TMR_W'(DEF_TIMEOUT);

    slp_state_t       state_q, state_d;
    logic [TMR_W-1:0] tmo_q;
    logic             start_req;
    logic             in_req;
    logic             us_tick;
    logic             tmo_expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmo_q <= TMO_RST;
        end else if (cfg_wr) begin
            tmo_q <= cfg_timeout;
        end
    end

    assign in_req    = (state_q == ST_SLEEP_REQ);
    assign start_req = (state_q == ST_NORMAL) && sleep_cmd;

    lps_us_tick #(
        .CLK_PER_US(CLK_PER_US)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .restart(start_req),
        .run    (in_req),
        .tick   (us_tick)
    );

    lps_req_timer #(
        .TMR_W(TMR_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(start_req),
        .run    (in_req),
        .tick   (us_tick),
        .limit  (tmo_q),
        .expire (tmo_expire)
    );

    lps_irq_flag u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_evt(lps_rx),
        .clr_evt(irq_clr),
        .flag   (irq_lps)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (sleep_cmd) state_d = ST_SLEEP_REQ;
            end
            ST_SLEEP_REQ: begin
                if (lps_rx)          state_d = ST_SLEEP_SILENT;
                else if (tmo_expire) state_d = ST_SLEEP_FAIL;
            end
            ST_SLEEP_SILENT: begin
                if (wake) state_d = ST_NORMAL;
            end
            ST_SLEEP_FAIL: begin
                if (fail_ack) state_d = ST_NORMAL;
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        lps_tx_req = 1'b0;
        in_normal  = 1'b0;
        in_silent  = 1'b0;
        in_fail    = 1'b0;
        unique case (state_q)
            ST_NORMAL:       in_normal  = 1'b1;
            ST_SLEEP_REQ:    lps_tx_req = 1'b1;
            ST_SLEEP_SILENT: in_silent  = 1'b1;
            ST_SLEEP_FAIL:   in_fail    = 1'b1;
            default:         in_normal  = 1'b1;
        endcase
    end

endmodule

module lps_sleep_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sleep_cmd,
    input logic lps_rx,
    input logic wake,
    input logic fail_ack,
    input logic irq_clr,
    input logic lps_tx_req,
    input logic in_normal,
    input logic in_silent,
    input logic in_fail,
    input logic irq_lps
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (in_normal && !lps_tx_req && !irq_lps));

    // R11
    one_state_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({in_normal, lps_tx_req, in_silent, in_fail}));

    // R2
    enter_req_chk: assert property (@(posedge clk) disable iff (rst)
        (in_normal && sleep_cmd) |=> lps_tx_req);

    // R4
    lps_to_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (lps_tx_req && lps_rx) |=> in_silent);

    // R3
    fail_from_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_fail) |-> $past(lps_tx_req));

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fail && fail_ack) |=> in_normal);

    // R10
    silent_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_silent && !wake) |=> in_silent);

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        lps_rx |=> irq_lps);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !lps_rx) |=> !irq_lps);

endmodule

bind lps_sleep_ctrl lps_sleep_ctrl_chk u_lps_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_cmd (sleep_cmd),
    .lps_rx    (lps_rx),
    .wake      (wake),
    .fail_ack  (fail_ack),
    .irq_clr   (irq_clr),
    .lps_tx_req(lps_tx_req),
    .in_normal (in_normal),
    .in_silent (in_silent),
    .in_fail   (in_fail),
    .irq_lps   (irq_lps)
);

// File: tb/lps_sleep_ctrl_bench.sv
module lps_sleep_ctrl_bench;
    localparam int K     = 2;
    localparam int TMR_W = 16;
    localparam int DEF_N = 16000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_cmd = 1'b0, lps_rx = 1'b0, wake = 1'b0, fail_ack = 1'b0, irq_clr = 1'b0;
    logic cfg_wr = 1'b0;
    logic [TMR_W-1:0] cfg_timeout = '0;
    logic lps_tx_req, in_normal, in_silent, in_fail, irq_lps;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    lps_sleep_ctrl #(
        .CLK_PER_US (K),
        .TMR_W      (TMR_W),
        .DEF_TIMEOUT(DEF_N)
    ) u_lps_sleep_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sleep_cmd  (sleep_cmd),
        .lps_rx     (lps_rx),
        .wake       (wake),
        .fail_ack   (fail_ack),
        .irq_clr    (irq_clr),
        .cfg_wr     (cfg_wr),
        .cfg_timeout(cfg_timeout),
        .lps_tx_req (lps_tx_req),
        .in_normal  (in_normal),
        .in_silent  (in_silent),
        .in_fail    (in_fail),
        .irq_lps    (irq_lps)
    );

    // state codes: 0 NORMAL, 1 SLEEP_REQ, 2 SLEEP_SILENT, 3 SLEEP_FAIL, 7 illegal
    function automatic int st_code();
        int ones;
        ones = int'(in_normal) + int'(lps_tx_req) + int'(in_silent) + int'(in_fail);
        if (ones != 1) return 7;
        if (in_normal)  return 0;
        if (lps_tx_req) return 1;
        if (in_silent)  return 2;
        return 3;
    endfunction

    task automatic check(input string req, input int exp_st, input logic exp_irq);
        int st;
        st = st_code();
        n_tests++;
        if (st != exp_st || irq_lps !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: state=%0d irq=%0b expected state=%0d irq=%0b",
                     req, st, irq_lps, exp_st, exp_irq);
        end
    endtask

    // drive at the falling edge, pass one rising edge, return at the next falling edge
    task automatic step(input logic c, input logic r, input logic w, input logic a, input logic k);
        sleep_cmd = c; lps_rx = r; wake = w; fail_ack = a; irq_clr = k;
        @(posedge clk);
        @(negedge clk);
        sleep_cmd = 0; lps_rx = 0; wake = 0; fail_ack = 0; irq_clr = 0;
    endtask

    task automatic set_timeout(input int n);
        cfg_wr = 1'b1; cfg_timeout = TMR_W'(n);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // vector: {req[3:0], cmd, rx, wake, ack, clr, exp_state[1:0], exp_irq}
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {4'd8,  5'b01000, 2'd0, 1'b1},  // R8 lps_rx in NORMAL sets flag, no move
        {4'd8,  5'b00001, 2'd0, 1'b0},  // R8 clear
        {4'd2,  5'b00110, 2'd0, 1'b0},  // R2 wake/ack in NORMAL ignored
        {4'd2,  5'b10000, 2'd1, 1'b0},  // R2 enter SLEEP_REQ
        {4'd3,  5'b10110, 2'd1, 1'b0},  // R3 stays in REQ, strobes ignored
        {4'd3,  5'b00000, 2'd1, 1'b0},  // R3 still requesting
        {4'd4,  5'b01000, 2'd2, 1'b1},  // R4 LPS -> SILENT, irq set
        {4'd10, 5'b10000, 2'd2, 1'b1},  // R10 sleep_cmd ignored in SILENT
        {4'd10, 5'b00010, 2'd2, 1'b1},  // R10 fail_ack ignored in SILENT
        {4'd8,  5'b01001, 2'd2, 1'b1},  // R8 set wins over clear
        {4'd8,  5'b00001, 2'd2, 1'b0},  // R8 clear
        {4'd10, 5'b00100, 2'd0, 1'b0},  // R10 wake -> NORMAL
        {4'd11, 5'b00000, 2'd0, 1'b0}   // R11 idle NORMAL
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [11:0] v;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 0, 1'b0);

        // R7 default timeout: fail after DEF_N*K edges
        step(1, 0, 0, 0, 0);
        check("R7 default entry", 1, 1'b0);
        for (int i = 1; i < DEF_N * K; i++) step(0, 0, 0, 0, 0);
        check("R7 default timeout not yet", 1, 1'b0);
        step(0, 0, 0, 0, 0);
        check("R7 default timeout expired", 3, 1'b0);
        check("R3 tx request dropped on fail", 3, 1'b0);
        step(1, 0, 1, 0, 0);
        check("R9 wake and sleep_cmd ignored in FAIL", 3, 1'b0);
        step(0, 0, 0, 1, 0);
        check("R9 ack returns to NORMAL", 0, 1'b0);

        // table walk with long timeout
        set_timeout(50);
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            step(v[7], v[6], v[5], v[4], v[3]);
            check($sformatf("R%0d vector %0d", v[11:8], i), int'(v[2:1]), v[0]);
        end

        // R5 exact fail timing with N=3
        set_timeout(3);
        step(1, 0, 0, 0, 0);
        for (int i = 1; i < 3 * K; i++) step(0, 0, 0, 0, 0);
        check("R5 one edge before expiry", 1, 1'b0);
        step(0, 0, 0, 0, 0);
        check("R5 fail at N*K edges", 3, 1'b0);
        step(0, 0, 0, 1, 0);
        check("R9 ack", 0, 1'b0);

        // R6 LPS on the expiry edge wins; also proves restart of the count (R5)
        step(1, 0, 0, 0, 0);
        for (int i = 1; i < 3 * K; i++) step(0, 0, 0, 0, 0);
        check("R5 restarted count still in REQ", 1, 1'b0);
        step(0, 1, 0, 0, 0);
        check("R6 LPS beats expiry", 2, 1'b1);
        step(0, 0, 1, 0, 1);
        check("R10 wake from SILENT", 0, 1'b0);

        // R1 reset during SLEEP_REQ with flag set
        step(0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        check("R2 entry before reset", 1, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset from SLEEP_REQ", 0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule